// File: doc/BRIEF.md
# Five-State Multicycle Register Processor

This block is a small sequential processor that works on one instruction at a time. Each instruction passes through five named states, always in the same order and each one clock long: FETCH (state 1), DECODE (state 2, registers read), ALU (state 3), MEM (state 4) and WB (state 5, register write-back). The transitions are FETCH→DECODE, DECODE→ALU, ALU→MEM, MEM→WB and WB→FETCH. A sixth condition, halted, holds the machine in FETCH. Every instruction uses all five states, including states in which it has no work to do.

The register file has four 16-bit registers, A, B, C and D. An instruction can access each register as a whole word, or as its upper or lower byte. The operations are register-plus-register add, a move of an immediate literal, and a move from a memory-direct address. Instructions, operands and data share one synchronous read port with one cycle of latency. A memory address register drives that port. The write-back trace outputs and the state number output let an environment watch each instruction retire.

Top module: `cpu5_core`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `dbg_state` is 1, `mem_addr` is 0, `halted`, `wb_valid`, `flag_z` and `flag_c` are 0. Reset also clears all four registers.
- R2: States run in the fixed order 1,2,3,4,5,1, one cycle each. Only one instruction is in flight, so an instruction that starts its FETCH in cycle n retires in cycle n+4, and the next one fetches in cycle n+5.
- R3: Instruction word layout: bits [15:12] opcode, [11:9] destination select, [8:6] source select, bit 5 size (0 word, 1 byte). Select bits [1:0] give the register index (0=A, 1=B, 2=C, 3=D). In byte mode, select bit 2 picks the upper byte (1) or the lower byte (0). Opcodes: 0 no-op, 1 add, 2 move immediate, 3 move from memory, 15 halt. Every other opcode behaves as a no-op.
- R4: Add reads destination and source in DECODE, sums them in ALU, does nothing in MEM, and writes destination+source (modulo the access width) in WB. In WB, `wb_valid` is 1, `wb_reg` is the register index and `wb_value` is the register's new 16-bit value.
- R5: Move immediate writes the operand word, which follows the instruction word, to the destination. In byte mode it writes the operand's low 8 bits.
- R6: Move from memory treats the operand word as an address. It reads memory there in MEM, with `mem_rd` high and `mem_addr` equal to that address, and writes the data to the destination in WB (the low 8 bits in byte mode).
- R7: A byte write changes only the selected half; the other half of the register keeps its value.
- R8: The program counter advances by 2 after move immediate and move from memory, and by 1 after every other instruction.
- R9: Add sets `flag_z` when its result is zero and `flag_c` on carry out of the access width (bit 16 for word, bit 8 for byte). The flags change only at the end of an add's WB. Other instructions leave them unchanged.
- R10: After the WB of a halt instruction, `halted` is 1, `dbg_state` stays 1, `mem_rd` stays 0 and no write-back occurs until reset.
- R11: In FETCH (not halted), `mem_rd` is 1 and `mem_addr` is the program counter. Read data appears on `mem_rdata` one cycle after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | ADDR_W | Memory address register output |
| mem_rd | output | 1 | Memory read request |
| mem_rdata | input | 16 | Read data, valid one cycle after the read |
| halted | output | 1 | Sequencer stopped by a halt instruction |
| dbg_state | output | 3 | Current state number, 1 to 5 |
| wb_valid | output | 1 | A register write happens this cycle |
| wb_reg | output | 2 | Index of the register being written |
| wb_value | output | 16 | New full-word value of that register |
| flag_z | output | 1 | Zero flag from the last add |
| flag_c | output | 1 | Carry flag from the last add |

## Verification
The assertions check on every cycle that the state number stays in range and follows the fixed five-step order. They also check that fetch issues a read, that write-back appears only in state 5, that flags move only at the end of state 5, and that halt holds. The bench scenarios show the data results: sums at each width, the carry and zero results, byte writes that keep the other half, literal versus address operands, and program counter steps past operand words. These results can only be seen by running a program and comparing the retired values with values worked out by hand.

// File: rtl/cpu5_pkg.sv
package cpu5_pkg;

    localparam int DATA_W = 16;
    localparam int BYTE_W = DATA_W / 2;
    localparam int NREG   = 4;
    localparam int IDX_W  = $clog2(NREG);
    localparam int SEL_W  = IDX_W + 1;
    localparam int OPC_W  = 4;

    localparam int OPC_LSB  = DATA_W - OPC_W;
    localparam int DST_LSB  = OPC_LSB - SEL_W;
    localparam int SRC_LSB  = DST_LSB - SEL_W;
    localparam int SIZE_BIT = SRC_LSB - 1;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd1,
        ST_DECODE = 3'd2,
        ST_ALU    = 3'd3,
        ST_MEM    = 3'd4,
        ST_WB     = 3'd5
    } cpu_state_t;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP  = 4'h0,
        OP_ADD  = 4'h1,
        OP_MOVI = 4'h2,
        OP_MOVM = 4'h3,
        OP_HALT = 4'hF
    } opcode_t;

    function automatic logic has_operand(input logic [OPC_W-1:0] op);
        return (op == OP_MOVI) || (op == OP_MOVM);
    endfunction

    function automatic logic writes_reg(input logic [OPC_W-1:0] op);
        return (op == OP_ADD) || (op == OP_MOVI) || (op == OP_MOVM);
    endfunction

endpackage

// File: rtl/cpu5_regfile.sv
module cpu5_regfile
    import cpu5_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  ra_sel,
    input  logic [SEL_W-1:0]  rb_sel,
    input  logic              rd_byte,
    output logic [DATA_W-1:0] ra_data,
    output logic [DATA_W-1:0] rb_data,
    input  logic              we,
    input  logic [SEL_W-1:0]  wsel,
    input  logic              wbyte,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] wmerged
);

    logic [DATA_W-1:0] regs [NREG];
    logic [DATA_W-1:0] cur;

    function automatic logic [DATA_W-1:0] pick(input logic [DATA_W-1:0] w,
                                              input logic hi, input logic bsz);
        if (!bsz)
            return w;
        else if (hi)
            return {{BYTE_W{1'b0}}, w[DATA_W-1:BYTE_W]};
        else
            return {{BYTE_W{1'b0}}, w[BYTE_W-1:0]};
    endfunction

    assign ra_data = pick(regs[ra_sel[IDX_W-1:0]], ra_sel[SEL_W-1], rd_byte);
    assign rb_data = pick(regs[rb_sel[IDX_W-1:0]], rb_sel[SEL_W-1], rd_byte);

    always_comb begin
        cur = regs[wsel[IDX_W-1:0]];
        if (!wbyte)
            wmerged = wdata;
        else if (wsel[SEL_W-1])
            wmerged = {wdata[BYTE_W-1:0], cur[BYTE_W-1:0]};
        else
            wmerged = {cur[DATA_W-1:BYTE_W], wdata[BYTE_W-1:0]};
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (we && (wsel[IDX_W-1:0] == IDX_W'(g)))
                regs[g] <= wmerged;
        end
    end

endmodule

// File: rtl/cpu5_alu.sv
module cpu5_alu
    import cpu5_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              byte_sz,
    output logic [DATA_W-1:0] sum,
    output logic              carry,
    output logic              zero
);

    logic [DATA_W:0] full;

    always_comb begin
        full = {1'b0, a} + {1'b0, b};
        if (byte_sz) begin
            sum   = {{BYTE_W{1'b0}}, full[BYTE_W-1:0]};
            carry = full[BYTE_W];
            zero  = (full[BYTE_W-1:0] == '0);
        end else begin
            sum   = full[DATA_W-1:0];
            carry = full[DATA_W];
            zero  = (full[DATA_W-1:0] == '0);
        end
    end

endmodule

// File: rtl/cpu5_seq.sv
module cpu5_seq
    import cpu5_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       halt_req,
    output cpu_state_t state,
    output logic       halted,
    output logic       fetch_en,
    output logic       dec_en,
    output logic       alu_en,
    output logic       mem_en,
    output logic       wb_en
);

    cpu_state_t nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_FETCH;
            halted <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_WB && halt_req)
                halted <= 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_FETCH:  nxt = halted ? ST_FETCH : ST_DECODE;
            ST_DECODE: nxt = ST_ALU;
            ST_ALU:    nxt = ST_MEM;
            ST_MEM:    nxt = ST_WB;
            ST_WB:     nxt = ST_FETCH;
            default:   nxt = ST_FETCH;
        endcase
    end

    always_comb begin
        fetch_en = (state == ST_FETCH) && !halted;
        dec_en   = (state == ST_DECODE);
        alu_en   = (state == ST_ALU);
        mem_en   = (state == ST_MEM);
        wb_en    = (state == ST_WB);
    end

endmodule

// File: rtl/cpu5_core.sv
module cpu5_core
    import cpu5_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [15:0]       mem_rdata,
    output logic              halted,
    output logic [2:0]        dbg_state,
    output logic              wb_valid,
    output logic [1:0]        wb_reg,
    output logic [15:0]       wb_value,
    output logic              flag_z,
    output logic              flag_c
);

    cpu_state_t        state;
    logic              fetch_en, dec_en, alu_en, mem_en, wb_en;
    logic [ADDR_W-1:0] pc, mar, pc_next;
    logic [OPC_W-1:0]  ir_op;
    logic [SEL_W-1:0]  ir_dst;
    logic              ir_byte;
    logic [DATA_W-1:0] opa, opb, res, ra_data, rb_data, alu_sum, wdata, wmerged;
    logic              res_c, res_z, alu_c, alu_z, fz, fc;
    logic [OPC_W-1:0]  dec_op;

    assign dec_op = mem_rdata[OPC_LSB +: OPC_W];

    cpu5_seq seq_i (
        .clk(clk), .rst(rst), .halt_req(ir_op == OP_HALT),
        .state(state), .halted(halted),
        .fetch_en(fetch_en), .dec_en(dec_en), .alu_en(alu_en),
        .mem_en(mem_en), .wb_en(wb_en)
    );

    cpu5_regfile rf_i (
        .clk(clk), .rst(rst),
        .ra_sel(mem_rdata[DST_LSB +: SEL_W]),
        .rb_sel(mem_rdata[SRC_LSB +: SEL_W]),
        .rd_byte(mem_rdata[SIZE_BIT]),
        .ra_data(ra_data), .rb_data(rb_data),
        .we(wb_valid), .wsel(ir_dst), .wbyte(ir_byte),
        .wdata(wdata), .wmerged(wmerged)
    );

    cpu5_alu alu_i (
        .a(opa), .b(opb), .byte_sz(ir_byte),
        .sum(alu_sum), .carry(alu_c), .zero(alu_z)
    );

    assign pc_next = pc + (has_operand(ir_op) ? ADDR_W'(2) : ADDR_W'(1));
    assign wdata   = (ir_op == OP_MOVM) ? mem_rdata : res;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc      <= '0;
            mar     <= '0;
            ir_op   <= OP_NOP;
            ir_dst  <= '0;
            ir_byte <= 1'b0;
            opa     <= '0;
            opb     <= '0;
            res     <= '0;
            res_c   <= 1'b0;
            res_z   <= 1'b0;
            fz      <= 1'b0;
            fc      <= 1'b0;
        end else begin
            if (fetch_en)
                mar <= pc + ADDR_W'(1);
            if (dec_en) begin
                ir_op   <= dec_op;
                ir_dst  <= mem_rdata[DST_LSB +: SEL_W];
                ir_byte <= mem_rdata[SIZE_BIT];
                opa     <= ra_data;
                opb     <= rb_data;
            end
            if (alu_en) begin
                res   <= (ir_op == OP_MOVI) ? mem_rdata : alu_sum;
                res_c <= alu_c;
                res_z <= alu_z;
                if (ir_op == OP_MOVM)
                    mar <= mem_rdata[ADDR_W-1:0];
            end
            if (wb_en) begin
                pc  <= pc_next;
                mar <= pc_next;
                if (ir_op == OP_ADD) begin
                    fz <= res_z;
                    fc <= res_c;
                end
            end
        end
    end

    always_comb begin
        mem_addr  = mar;
        mem_rd    = fetch_en || (dec_en && has_operand(dec_op))
                    || (mem_en && ir_op == OP_MOVM);
        dbg_state = state;
        wb_valid  = wb_en && writes_reg(ir_op);
        wb_reg    = ir_dst[IDX_W-1:0];
        wb_value  = wmerged;
        flag_z    = fz;
        flag_c    = fc;
    end

endmodule

// File: rtl/cpu5_chk.sv
module cpu5_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] dbg_state,
    input logic       halted,
    input logic       mem_rd,
    input logic       wb_valid,
    input logic       flag_z,
    input logic       flag_c
);

    p_state_range_r2: assert property (@(posedge clk) disable iff (rst)
        (dbg_state >= 3'd1) && (dbg_state <= 3'd5));

    p_fetch_step_r2: assert property (@(posedge clk) disable iff (rst)
        (dbg_state == 3'd1 && !halted) |=> (dbg_state == 3'd2));

    p_decode_step_r2: assert property (@(posedge clk) disable iff (rst)
        (dbg_state == 3'd2) |=> (dbg_state == 3'd3));

    p_alu_step_r2: assert property (@(posedge clk) disable iff (rst)
        (dbg_state == 3'd3) |=> (dbg_state == 3'd4));

    p_mem_step_r2: assert property (@(posedge clk) disable iff (rst)
        (dbg_state == 3'd4) |=> (dbg_state == 3'd5));

    p_wb_step_r2: assert property (@(posedge clk) disable iff (rst)
        (dbg_state == 3'd5) |=> (dbg_state == 3'd1));

    p_fetch_read_r11: assert property (@(posedge clk) disable iff (rst)
        (dbg_state == 3'd1 && !halted) |-> mem_rd);

    p_wb_in_state5_r4: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (dbg_state == 3'd5));

    p_flags_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (dbg_state != 3'd5) |=> $stable({flag_z, flag_c}));

    p_halt_hold_r10: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && dbg_state == 3'd1 && !mem_rd && !wb_valid));

endmodule

bind cpu5_core cpu5_chk chk_i (
    .clk(clk), .rst(rst), .dbg_state(dbg_state), .halted(halted),
    .mem_rd(mem_rd), .wb_valid(wb_valid), .flag_z(flag_z), .flag_c(flag_c)
);

// File: tb/cpu5_core_tb.sv
`timescale 1ns/1ps
module cpu5_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  mem_addr;
    logic        mem_rd;
    logic [15:0] mem_rdata = 16'h0;
    logic        halted, wb_valid, flag_z, flag_c;
    logic [2:0]  dbg_state;
    logic [1:0]  wb_reg;
    logic [15:0] wb_value;

    logic [15:0] mem [256];
    int n_chk = 0, n_fail = 0, pp = 0, cnt = 0;
    int n_ev = 0, state_err = 0;
    logic [15:0] ev_val [32];
    logic [1:0]  ev_reg [32];
    int          ev_cyc [32];
    logic [7:0]  mem_seen;
    bit          done = 0;

    always #5 clk = ~clk;

    cpu5_core dut_i (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .halted(halted), .dbg_state(dbg_state),
        .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_value(wb_value),
        .flag_z(flag_z), .flag_c(flag_c)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (rst) cnt <= 0; else cnt <= cnt + 1;
    end

    always @(negedge clk) begin
        if (rst) begin
            n_ev = 0; state_err = 0;
        end else begin
            if (!halted && dbg_state != 3'((cnt % 5) + 1)) state_err++;
            if (dbg_state == 3'd4 && mem_rd) mem_seen = mem_addr;
            if (wb_valid && n_ev < 32) begin
                ev_val[n_ev] = wb_value; ev_reg[n_ev] = wb_reg;
                ev_cyc[n_ev] = cnt; n_ev++;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input logic [3:0] op, input logic [2:0] d,
                                        input logic [2:0] s, input logic b);
        return {op, d, s, b, 5'd0};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        pp = 0;
    endtask

    task automatic put(input logic [15:0] w);
        mem[pp] = w; pp++;
    endtask

    task automatic run_prog(input int n_instr, input string req);
        int waited = 0;
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        while (!halted && waited < 400) begin
            @(negedge clk); waited++;
        end
        chk({req, " R2 cycles to halt"}, cnt, 5 * n_instr);
        chk({req, " R2 state order"}, state_err, 0);
    endtask

    task automatic chk_ev(input int i, input logic [1:0] r, input logic [15:0] v,
                          input int instr_idx, input string req);
        chk({req, " write-back reg"}, ev_reg[i], r);
        chk({req, " write-back value"}, ev_val[i], v);
        chk({req, " R2 retire cycle"}, ev_cyc[i], 5 * instr_idx + 4);
    endtask

    // R3 R4 R5 R8: word moves, unknown opcode as no-op, word add
    task automatic t_word_add();
        clear_mem();
        put(enc(4'h2, 3'd0, 3'd0, 1'b0)); put(16'h1234);
        put(enc(4'h2, 3'd1, 3'd0, 1'b0)); put(16'h0F0F);
        put(enc(4'h7, 3'd2, 3'd0, 1'b0));
        put(enc(4'h1, 3'd0, 3'd1, 1'b0));
        put(enc(4'hF, 3'd0, 3'd0, 1'b0));
        run_prog(5, "word_add");
        chk("R3 event count (opcode 7 no write)", n_ev, 3);
        chk_ev(0, 2'd0, 16'h1234, 0, "R5 movi A");
        chk_ev(1, 2'd1, 16'h0F0F, 1, "R8 movi B after operand");
        chk_ev(2, 2'd0, 16'h2143, 3, "R4 add A+B");
        chk("R9 flag_z no carry add", flag_z, 1'b0);
        chk("R9 flag_c no carry add", flag_c, 1'b0);
    endtask

    // R7 R5: byte writes keep the other half
    task automatic t_bytes();
        clear_mem();
        put(enc(4'h2, 3'd0, 3'd0, 1'b0)); put(16'hABCD);
        put(enc(4'h2, 3'd4, 3'd0, 1'b1)); put(16'h0012);
        put(enc(4'h2, 3'd0, 3'd0, 1'b1)); put(16'hFF34);
        put(enc(4'hF, 3'd0, 3'd0, 1'b0));
        run_prog(4, "bytes");
        chk("R7 event count", n_ev, 3);
        chk_ev(1, 2'd0, 16'h12CD, 1, "R7 high byte write");
        chk_ev(2, 2'd0, 16'h1234, 2, "R5 R7 low byte literal low 8 bits");
    endtask

    // R6 R11: memory-direct moves
    task automatic t_mem();
        clear_mem();
        mem[8'h80] = 16'hBEEF; mem[8'h81] = 16'h5566;
        put(enc(4'h3, 3'd2, 3'd0, 1'b0)); put(16'h0080);
        put(enc(4'h3, 3'd3, 3'd0, 1'b1)); put(16'h0081);
        put(enc(4'h3, 3'd7, 3'd0, 1'b1)); put(16'h0080);
        put(enc(4'hF, 3'd0, 3'd0, 1'b0));
        run_prog(4, "mem");
        chk("R6 event count", n_ev, 3);
        chk_ev(0, 2'd2, 16'hBEEF, 0, "R6 movm word");
        chk_ev(1, 2'd3, 16'h0066, 1, "R6 movm low byte");
        chk_ev(2, 2'd3, 16'hEF66, 2, "R6 R7 movm high byte");
        chk("R6 mem address in MEM state", mem_seen, 8'h80);
    endtask

    // R9: carry and zero at word and byte widths
    task automatic t_flags();
        clear_mem();
        put(enc(4'h2, 3'd0, 3'd0, 1'b0)); put(16'hFFFF);
        put(enc(4'h2, 3'd1, 3'd0, 1'b0)); put(16'h0001);
        put(enc(4'h1, 3'd0, 3'd1, 1'b0));
        put(enc(4'h2, 3'd2, 3'd0, 1'b0)); put(16'h0005);
        put(enc(4'hF, 3'd0, 3'd0, 1'b0));
        run_prog(5, "flags_word");
        chk_ev(2, 2'd0, 16'h0000, 2, "R4 word add wraps");
        chk("R9 word zero kept after movi", flag_z, 1'b1);
        chk("R9 word carry kept after movi", flag_c, 1'b1);

        clear_mem();
        put(enc(4'h2, 3'd2, 3'd0, 1'b0)); put(16'h12F0);
        put(enc(4'h2, 3'd3, 3'd0, 1'b0)); put(16'h0110);
        put(enc(4'h1, 3'd2, 3'd3, 1'b1));
        put(enc(4'hF, 3'd0, 3'd0, 1'b0));
        run_prog(4, "flags_lowbyte");
        chk_ev(2, 2'd2, 16'h1200, 2, "R4 R7 low byte add");
        chk("R9 byte zero", flag_z, 1'b1);
        chk("R9 byte carry from bit 8", flag_c, 1'b1);

        clear_mem();
        put(enc(4'h2, 3'd2, 3'd0, 1'b0)); put(16'h12F0);
        put(enc(4'h2, 3'd3, 3'd0, 1'b0)); put(16'h0110);
        put(enc(4'h1, 3'd6, 3'd7, 1'b1));
        put(enc(4'hF, 3'd0, 3'd0, 1'b0));
        run_prog(4, "flags_highbyte");
        chk_ev(2, 2'd2, 16'h13F0, 2, "R4 R7 high byte add");
        chk("R9 high byte zero clear", flag_z, 1'b0);
        chk("R9 high byte carry clear", flag_c, 1'b0);
    endtask

    // R10: halt holds
    task automatic t_halt();
        int ev0;
        ev0 = n_ev;
        repeat (10) @(negedge clk);
        chk("R10 halted", halted, 1'b1);
        chk("R10 state stays 1", dbg_state, 3'd1);
        chk("R10 no read", mem_rd, 1'b0);
        chk("R10 no write-back", n_ev, ev0);
    endtask

    // R1 R11: reset clears state, flags, halt
    task automatic t_reset();
        clear_mem();
        put(enc(4'h2, 3'd0, 3'd0, 1'b0)); put(16'hFFFF);
        put(enc(4'h2, 3'd1, 3'd0, 1'b0)); put(16'h0001);
        put(enc(4'h1, 3'd0, 3'd1, 1'b0));
        put(enc(4'hF, 3'd0, 3'd0, 1'b0));
        run_prog(4, "pre_reset");
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk("R1 state", dbg_state, 3'd1);
        chk("R1 addr", mem_addr, 8'h00);
        chk("R1 halted", halted, 1'b0);
        chk("R1 flags", {flag_z, flag_c}, 2'b00);
        chk("R1 no write-back", wb_valid, 1'b0);
        mem[0] = enc(4'h1, 3'd0, 3'd1, 1'b0);
        mem[1] = enc(4'hF, 3'd0, 3'd0, 1'b0);
        @(negedge clk); rst = 1'b0;
        chk("R11 first fetch read", mem_rd, 1'b1);
        chk("R11 first fetch addr", mem_addr, 8'h00);
        repeat (5) @(negedge clk);
        chk("R1 registers cleared: A+B", ev_val[0], 16'h0000);
        repeat (6) @(negedge clk);
        chk("R1 R9 zero add after reset", {flag_z, flag_c}, 2'b10);
    endtask

    initial begin
        t_word_add();
        t_halt();
        t_bytes();
        t_mem();
        t_flags();
        t_reset();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule